// File: doc/BRIEF.md
# Registered Read-Only Store with Configurable Enable/Initialize Pin

This block is a 8192-word by 8-bit read-only store whose read path ends in an edge-triggered output register. It suits a pipelined microcode sequencer. On every rising clock edge the word at the present address is captured, so the address for the next cycle can be set up while the current word stays on the output. A stand-in for a tri-state pad, the `outEn` flag, tells the consumer when the output is driven. While `outEn` is low, `dataOut` is forced to zero.

A single control input, `ctlPin`, takes one of three meanings. A stored configuration byte selects which one:
- an immediate output enable,
- a clock-sampled output enable, or
- an immediate initialize. This loads a stored initialize word into the register and blocks the clock for as long as the pin is held low.

A synchronous program port fills three things one location per strobe: the array, the initialize word (program location 0x2000) and the configuration byte (program location 0x2001).

Top module: `cfg_reg_rom`

## Requirements
- R1: On each rising clock edge at which loading is allowed, the word stored at `addr` is captured. It appears on `dataOut` right after that edge whenever the output is enabled.
- R2: Changes to `addr` between two rising edges leave `dataOut` unchanged until the next rising edge.
- R3: With configuration byte 0x00 (the reset value), `outEn` equals the inverse of `ctlPin` without waiting for a clock. While `outEn` is low, `dataOut` reads 0x00.
- R4: With configuration byte 0x01, `ctlPin` is sampled on each rising edge. A high sample makes `outEn` low from that edge, and a low sample makes it high from that edge. Changes of `ctlPin` between edges do not affect `outEn`.
- R5: With configuration byte 0x02, `outEn` is always high. Driving `ctlPin` low puts the initialize word on `dataOut` without waiting for a clock.
- R6: With configuration byte 0x02, rising edges while `ctlPin` is low do not load the array. After `ctlPin` returns high, `dataOut` keeps the initialize word until the first rising edge that samples `ctlPin` high, and that edge loads the addressed word. This holds even for a low pulse that falls entirely between two edges.
- R7: An initialize word never programmed since reset reads 0x00, so initialize clears the register. An initialize word of 0xFF presets it.
- R8: A strobe on `pgmWe` writes `pgmData` at the clock edge. Program addresses 0x0000 to 0x1FFF write the array, 0x2000 writes the initialize word and 0x2001 writes the configuration byte. Program addresses above 0x2001 change nothing.
- R9: Reset sets the following to zero: the output register, the clock-sampled enable (which makes it disabled), the initialize word and the configuration byte.
- R10: Any configuration byte other than 0x00, 0x01 or 0x02 behaves as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 13 | Read address into the array |
| ctlPin | input | 1 | Shared enable/initialize control, active low |
| pgmWe | input | 1 | Program strobe, one write per clock |
| pgmAddr | input | 14 | Program location (array, initialize word, configuration byte) |
| pgmData | input | 8 | Program data |
| dataOut | output | 8 | Registered read data, zero while not driven |
| outEn | output | 1 | High when the output would be driven |

## Verification
The hardest case to reach from the ports is an initialize pulse that starts and ends between two clock edges. No edge ever samples it, yet the output must show the initialize word until the next edge and then return to array data. The bench reaches it with directed timing: it lowers and raises `ctlPin` one nanosecond apart inside a single clock phase.

The bench then checks `dataOut` before and after the following edge, for a cleared, a preset and an arbitrary initialize word. Random address and pin sequences under each configuration, including an out-of-range byte, cover the ordinary reads and the two enable styles.

// File: rtl/cfg_reg_rom_pkg.sv
package cfg_reg_rom_pkg;

  typedef enum logic [1:0] {
    PIN_ASYNC_EN = 2'd0,
    PIN_SYNC_EN  = 2'd1,
    PIN_INIT     = 2'd2
  } pinMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;    // capture array word at this edge
    logic showInit;  // present initialize word instead of register
    logic drive;     // output enabled
  } romStrobe_t;

endpackage

// File: rtl/cfg_reg_rom_ctrl.sv
module cfg_reg_rom_ctrl
  import cfg_reg_rom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlPin,
  input  logic [DATA_W-1:0] cfgByte,
  output romStrobe_t        strobe
);

  localparam logic [DATA_W-1:0] CFG_SYNC = DATA_W'(1);
  localparam logic [DATA_W-1:0] CFG_INIT = DATA_W'(2);

  pinMode_e pinMode;
  logic     syncEn;
  logic     initN;
  logic     initSeen;

  // unknown configuration values fall back to the immediate enable
  always_comb begin
    if (cfgByte == CFG_SYNC)      pinMode = PIN_SYNC_EN;
    else if (cfgByte == CFG_INIT) pinMode = PIN_INIT;
    else                          pinMode = PIN_ASYNC_EN;
  end

  // clock-sampled enable, disabled out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncEn <= 1'b0;
    else       syncEn <= ~ctlPin;
  end

  assign initN = ~((pinMode == PIN_INIT) & ~ctlPin);

  // set at once by an initialize request, cleared by the first edge after release
  always_ff @(posedge clk or negedge rstN or negedge initN) begin
    if (!rstN)       initSeen <= 1'b0;
    else if (!initN) initSeen <= 1'b1;
    else             initSeen <= 1'b0;
  end

  always_comb begin
    strobe.loadEn   = initN;
    strobe.showInit = initSeen;
    unique case (pinMode)
      PIN_ASYNC_EN: strobe.drive = ~ctlPin;
      PIN_SYNC_EN:  strobe.drive = syncEn;
      default:      strobe.drive = 1'b1;
    endcase
  end

endmodule

// File: rtl/cfg_reg_rom_dpath.sv
module cfg_reg_rom_dpath
  import cfg_reg_rom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pgmWe,
  input  logic [ADDR_W:0]   pgmAddr,
  input  logic [DATA_W-1:0] pgmData,
  input  romStrobe_t        strobe,
  output logic [DATA_W-1:0] cfgByte,
  output logic [DATA_W-1:0] initWord,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PGM_W = ADDR_W + 1;
  localparam logic [PGM_W-1:0] INIT_LOC = PGM_W'(DEPTH);
  localparam logic [PGM_W-1:0] CFG_LOC  = PGM_W'(DEPTH + 1);

  logic [DATA_W-1:0] romArray [DEPTH];
  logic [DATA_W-1:0] pipeReg;

  always_ff @(posedge clk) begin
    if (pgmWe && !pgmAddr[ADDR_W]) romArray[pgmAddr[ADDR_W-1:0]] <= pgmData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initWord <= '0;
      cfgByte  <= '0;
    end else if (pgmWe) begin
      if (pgmAddr == INIT_LOC) initWord <= pgmData;
      if (pgmAddr == CFG_LOC)  cfgByte  <= pgmData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pipeReg <= '0;
    else if (strobe.loadEn) pipeReg <= romArray[addr];
  end

  always_comb begin
    if (!strobe.drive)        dataOut = '0;
    else if (strobe.showInit) dataOut = initWord;
    else                      dataOut = pipeReg;
  end

endmodule

// File: rtl/cfg_reg_rom.sv
module cfg_reg_rom
  import cfg_reg_rom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctlPin,
  input  logic              pgmWe,
  input  logic [ADDR_W:0]   pgmAddr,
  input  logic [DATA_W-1:0] pgmData,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  romStrobe_t        strobe;
  logic [DATA_W-1:0] cfgByte;
  logic [DATA_W-1:0] initWord;

  cfg_reg_rom_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctlPin (ctlPin),
    .cfgByte(cfgByte),
    .strobe (strobe)
  );

  cfg_reg_rom_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .pgmWe   (pgmWe),
    .pgmAddr (pgmAddr),
    .pgmData (pgmData),
    .strobe  (strobe),
    .cfgByte (cfgByte),
    .initWord(initWord),
    .dataOut (dataOut)
  );

  assign outEn = strobe.drive;

endmodule

// File: rtl/cfg_reg_rom_chk.sv
module cfg_reg_rom_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlPin,
  input logic              pgmWe,
  input logic [ADDR_W:0]   pgmAddr,
  input logic [DATA_W-1:0] cfgByte,
  input logic [DATA_W-1:0] initWord,
  input logic [DATA_W-1:0] dataOut,
  input logic              outEn
);

  localparam logic [ADDR_W:0] LAST_LOC = (ADDR_W+1)'((1 << ADDR_W) + 1);

  logic isSync, isInit, isAsync;
  assign isSync  = (cfgByte == DATA_W'(1));
  assign isInit  = (cfgByte == DATA_W'(2));
  assign isAsync = !isSync && !isInit;

  AST_ASYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    isAsync |-> (outEn == !ctlPin)) else $error("async enable"); // R3

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (dataOut == '0)) else $error("disabled output nonzero"); // R3

  AST_SYNC_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (isSync && !pgmWe) |=> (outEn == !$past(ctlPin))) else $error("sync enable"); // R4

  AST_INIT_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    (isInit && !ctlPin) |-> (outEn && dataOut == initWord)) else $error("init word"); // R5

  AST_INIT_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    isInit |-> outEn) else $error("init mode disabled"); // R5

  AST_PGM_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (pgmWe && pgmAddr > LAST_LOC) |=> ($stable(cfgByte) && $stable(initWord)))
    else $error("out of range write"); // R8

endmodule

bind cfg_reg_rom cfg_reg_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctlPin  (ctlPin),
  .pgmWe   (pgmWe),
  .pgmAddr (pgmAddr),
  .cfgByte (cfgByte),
  .initWord(initWord),
  .dataOut (dataOut),
  .outEn   (outEn)
);

// File: tb/sim_cfg_reg_rom.sv
module sim_cfg_reg_rom;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ctlPin = 1'b0;
  logic              pgmWe = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W:0]   pgmAddr = '0;
  logic [7:0]        pgmData = '0;
  logic [7:0]        dataOut;
  logic              outEn;

  int checks = 0;
  int errors = 0;
  logic [7:0] bMem [DEPTH];
  logic [7:0] bInit = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_reg_rom u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .ctlPin(ctlPin),
    .pgmWe(pgmWe), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .dataOut(dataOut), .outEn(outEn)
  );

  function automatic logic [7:0] expOut(input logic en, input logic [7:0] val);
    return en ? val : 8'h00;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pgm(input logic [ADDR_W:0] a, input logic [7:0] d);
    pgmAddr = a;
    pgmData = d;
    pgmWe   = 1'b1;
    tick();
    pgmWe   = 1'b0;
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, input string req);
    addr = a;
    tick();
    chk(dataOut === bMem[a], req, dataOut, bMem[a]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0t expected finish", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] expD;
    logic       expE;
    logic [ADDR_W-1:0] a;
    void'($urandom(32'h5eed_2001));

    // R9: reset state under default configuration
    tick(); tick();
    chk(dataOut === 8'h00 && outEn === 1'b1, "R9 reset register zero", dataOut, 8'h00);
    rstN = 1'b1;
    tick();
    chk(dataOut === 8'h00, "R9 register zero after release", dataOut, 8'h00);

    // R8: fill the array
    for (int i = 0; i < DEPTH; i++) begin
      bMem[i] = 8'($urandom);
      pgm((ADDR_W+1)'(i), bMem[i]);
    end
    // R8: out-of-range writes
    pgm(14'h2002, 8'h02);
    pgm(14'h3FFF, 8'h01);
    ctlPin = 1'b1; #1;
    chk(outEn === 1'b0, "R8 config untouched by high write", {7'd0, outEn}, 8'h00);
    ctlPin = 1'b0; #1;
    readAt(13'h0002, "R8 array not aliased");
    readAt(13'h1FFF, "R8 last array word");

    // R1/R2: random reads, address moved between edges
    for (int i = 0; i < 200; i++) begin
      a = ADDR_W'($urandom);
      readAt(a, "R1 captured word");
      addr = ADDR_W'($urandom);
      #3;
      chk(dataOut === bMem[a], "R2 stable between edges", dataOut, bMem[a]);
    end

    // R3: immediate enable
    ctlPin = 1'b1; #1;
    chk(outEn === 1'b0 && dataOut === 8'h00, "R3 disable without clock", dataOut, 8'h00);
    ctlPin = 1'b0; #1;
    a = addr;
    tick();
    chk(outEn === 1'b1 && dataOut === bMem[a], "R3 re-enable", dataOut, bMem[a]);

    // R10: undefined configuration behaves like 0x00
    pgm(14'h2001, 8'h05);
    ctlPin = 1'b1; #1;
    chk(outEn === 1'b0, "R10 odd config acts immediate", {7'd0, outEn}, 8'h00);
    ctlPin = 1'b0; #1;
    chk(outEn === 1'b1, "R10 odd config re-enable", {7'd0, outEn}, 8'h01);

    // R4: clock-sampled enable
    pgm(14'h2001, 8'h01);
    expE = 1'b1;
    for (int i = 0; i < 200; i++) begin
      ctlPin = 1'($urandom);
      addr   = ADDR_W'($urandom);
      #1;
      chk(outEn === expE, "R4 no change between edges", {7'd0, outEn}, {7'd0, expE});
      a = addr;
      tick();
      expE = ~ctlPin;
      expD = expOut(expE, bMem[a]);
      chk(outEn === expE && dataOut === expD, "R4 sampled enable", dataOut, expD);
    end
    ctlPin = 1'b0;
    tick();

    // R5/R6/R7: initialize, word never programmed -> clear
    pgm(14'h2001, 8'h02);
    ctlPin = 1'b0; #1;
    chk(outEn === 1'b1 && dataOut === 8'h00, "R7 clear on init", dataOut, 8'h00);
    for (int i = 0; i < 3; i++) begin
      addr = ADDR_W'($urandom);
      tick();
      chk(dataOut === bInit, "R6 edges ignored while held", dataOut, bInit);
    end
    ctlPin = 1'b1; #1;
    chk(dataOut === bInit, "R6 held after release", dataOut, bInit);
    a = ADDR_W'($urandom);
    readAt(a, "R6 resume loading");

    // R7: preset word, short pulse between edges
    pgm(14'h2000, 8'hFF);
    bInit = 8'hFF;
    ctlPin = 1'b0; #1;
    ctlPin = 1'b1; #1;
    chk(outEn === 1'b1 && dataOut === 8'hFF, "R7 preset on short pulse", dataOut, 8'hFF);
    a = ADDR_W'($urandom);
    readAt(a, "R6 load after short pulse");

    // R5: arbitrary initialize words, random holds
    for (int i = 0; i < 20; i++) begin
      bInit = 8'($urandom);
      pgm(14'h2000, bInit);
      ctlPin = 1'b0; #1;
      chk(outEn === 1'b1 && dataOut === bInit, "R5 init word at once", dataOut, bInit);
      for (int k = 0; k < int'($urandom_range(3)); k++) begin
        addr = ADDR_W'($urandom);
        tick();
        chk(dataOut === bInit, "R6 held across edges", dataOut, bInit);
      end
      ctlPin = 1'b1; #1;
      a = ADDR_W'($urandom);
      readAt(a, "R6 first edge after release");
      chk(outEn === 1'b1, "R5 always enabled", {7'd0, outEn}, 8'h01);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule